// File: doc/BRIEF.md
# Sticky Interrupt Flag and Status Register

This block gathers three single-cycle event strobes from a real-time clock core (a periodic tick, an alarm match and an end-of-update notice) into sticky flags. Each flag is masked by its own enable input. The masked result forms a summary flag and drives an active-low interrupt request line. The flags appear on a small register read port, together with a read-only status byte that reports that the time and RAM contents are valid.

Software reads the flag byte to find out why the interrupt fired. That read also clears every flag, which releases the interrupt line. An event strobe that lands in the same cycle as the clearing read is not lost: it stays set after the clear. It is then reported by the next read.

The read port is a plain strobe with an address and combinational read data, and it has no back-pressure. `rd_data` is valid in the same cycle that `rd_en` is high. Any clear that the read causes takes effect at the following rising clock edge. Every read completes in one cycle.

Top module: `irqf_regfile`

## Requirements
- R1: After reset all three source flags are 0, `irq_n` is 1, and a read of the flag byte (address 12) returns 0x00.
- R2: A high `evt_periodic`, `evt_alarm` or `evt_update` in a cycle sets flag bit 6, 5 or 4 respectively at the next rising edge, whatever the value of the matching enable input.
- R3: A source flag stays set, with or without further events, until it is cleared by a read of address 12.
- R4: Bit 7 of the flag byte is 1 exactly when at least one of the pairs (bit 6, `en_periodic`), (bit 5, `en_alarm`) and (bit 4, `en_update`) has both members at 1. It follows a change of an enable input in the same cycle.
- R5: `irq_n` is always the inverse of the bit 7 value described in R4.
- R6: When `rd_en` is high with `rd_addr` = 12, `rd_data` shows the flag byte as it stands in that cycle. All source flags are cleared at the next rising edge.
- R7: An event strobe that is high in the same cycle as a read of address 12 leaves its flag set after that read's clear. The read in that cycle still shows the value before the event.
- R8: Flag byte bits 3:0 always read 0. A read of address 13 returns 0x80: bit 7 is the valid flag, 1 from reset onward, and bits 6:0 are 0.
- R9: A read of any address other than 12 leaves the flags unchanged. Addresses other than 12 and 13 read 0x00, and `rd_data` is 0x00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_periodic | input | 1 | Periodic tick strobe, one cycle per event |
| evt_alarm | input | 1 | Alarm match strobe |
| evt_update | input | 1 | Update-ended strobe |
| en_periodic | input | 1 | Enable for the periodic flag in the summary |
| en_alarm | input | 1 | Enable for the alarm flag in the summary |
| en_update | input | 1 | Enable for the update flag in the summary |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register address for the read |
| rd_data | output | 8 | Read data, valid in the cycle of `rd_en` |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions take the event strobes to be synchronous to `clk`. They take `rd_en` and `rd_addr` to be stable around the rising edge, so that one high cycle of `rd_en` counts as exactly one read. The flag checks also assume that the only thing that clears a flag is a read of address 12, with no other agent touching the flags.

The bench drives every input on the falling edge and holds it through the following rising edge. Each read lasts one cycle. The bench mixes directed cases, covering simultaneous events, a read that collides with an event, and reads of the status and unused addresses, with a long pseudo-random run over all the inputs.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  // Number of event sources feeding the flag byte
  localparam int unsigned NUM_SRC   = 3;
  // Bit position of the lowest source flag in the flag byte
  localparam int unsigned FLAG_LSB  = 4;
  // Bit position of the summary flag and the valid flag
  localparam int unsigned TOP_BIT   = 7;

  // Source index order inside the flag vector (LSB first)
  typedef enum logic [1:0] {
    SRC_UPDATE   = 2'd0,
    SRC_ALARM    = 2'd1,
    SRC_PERIODIC = 2'd2
  } src_idx_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irqf_cell.sv
module irqf_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic flag
);
  // A clear wins over the held value, but an event in the clearing
  // cycle still sets the flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= evt;
    else          flag <= flag | evt;
  end
endmodule

// File: rtl/irqf_summary.sv
module irqf_summary
  import irqf_pkg::*;
(
  input  src_vec_t flags,
  input  src_vec_t enables,
  output logic     irq,
  output logic     irq_n
);
  src_vec_t masked;

  always_comb begin
    masked = flags & enables;
    irq    = |masked;
    irq_n  = ~irq;
  end
endmodule

// File: rtl/irqf_rdmux.sv
module irqf_rdmux
  import irqf_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned FLAG_ADDR  = 12,
  parameter int unsigned VALID_ADDR = 13
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  src_vec_t          flags,
  input  logic              irq,
  input  logic              valid,
  output logic              hit_flags,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(FLAG_ADDR);
  localparam logic [ADDR_W-1:0] A_VALID = ADDR_W'(VALID_ADDR);

  logic [DATA_W-1:0] flag_byte;
  logic [DATA_W-1:0] valid_byte;

  always_comb begin
    flag_byte                               = '0;
    flag_byte[FLAG_LSB +: NUM_SRC]          = flags;
    flag_byte[TOP_BIT]                      = irq;
    valid_byte                              = '0;
    valid_byte[TOP_BIT]                     = valid;
  end

  always_comb begin
    hit_flags = rd_en && (rd_addr == A_FLAG);
    rd_data   = '0;
    if (rd_en) begin
      unique case (rd_addr)
        A_FLAG:  rd_data = flag_byte;
        A_VALID: rd_data = valid_byte;
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqf_regfile.sv
module irqf_regfile
  import irqf_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned FLAG_ADDR  = 12,
  parameter int unsigned VALID_ADDR = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_periodic,
  input  logic              evt_alarm,
  input  logic              evt_update,
  input  logic              en_periodic,
  input  logic              en_alarm,
  input  logic              en_update,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  src_vec_t evt_vec;
  src_vec_t en_vec;
  src_vec_t flags_q;
  logic     rd_clear;
  logic     irq;
  logic     valid_q;

  always_comb begin
    evt_vec               = '0;
    evt_vec[SRC_UPDATE]   = evt_update;
    evt_vec[SRC_ALARM]    = evt_alarm;
    evt_vec[SRC_PERIODIC] = evt_periodic;
    en_vec                = '0;
    en_vec[SRC_UPDATE]    = en_update;
    en_vec[SRC_ALARM]     = en_alarm;
    en_vec[SRC_PERIODIC]  = en_periodic;
  end

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_cell
    irqf_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (evt_vec[gi]),
      .clr  (rd_clear),
      .flag (flags_q[gi])
    );
  end

  // Valid-time status: set by reset, nothing in this block lowers it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b1;
    else        valid_q <= valid_q;
  end

  irqf_summary u_sum (
    .flags  (flags_q),
    .enables(en_vec),
    .irq    (irq),
    .irq_n  (irq_n)
  );

  irqf_rdmux #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .FLAG_ADDR (FLAG_ADDR),
    .VALID_ADDR(VALID_ADDR)
  ) u_rd (
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .flags    (flags_q),
    .irq      (irq),
    .valid    (valid_q),
    .hit_flags(rd_clear),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/irqf_regfile_chk.sv
module irqf_regfile_chk
  import irqf_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned FLAG_ADDR  = 12,
  parameter int unsigned VALID_ADDR = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_periodic,
  input logic              evt_alarm,
  input logic              evt_update,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_n,
  input src_vec_t          flags_q
);
  logic rd_f;
  logic rd_v;
  logic any_evt;
  assign rd_f    = rd_en && (rd_addr == ADDR_W'(FLAG_ADDR));
  assign rd_v    = rd_en && (rd_addr == ADDR_W'(VALID_ADDR));
  assign any_evt = evt_periodic | evt_alarm | evt_update;

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_periodic |=> flags_q[SRC_PERIODIC]);
  assert_capture_alarm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_alarm |=> flags_q[SRC_ALARM]);
  assert_capture_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_update |=> flags_q[SRC_UPDATE]);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_f |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_irq_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_f |-> (irq_n == !rd_data[7]));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_f && !any_evt) |=> (flags_q == '0));

  assert_race_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_f && evt_alarm) |=> flags_q[SRC_ALARM]);

  assert_low_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_f |-> (rd_data[3:0] == 4'h0));
  assert_valid_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_v |-> (rd_data == DATA_W'(8'h80)));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rd_data == '0));
endmodule

bind irqf_regfile irqf_regfile_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .FLAG_ADDR (FLAG_ADDR),
  .VALID_ADDR(VALID_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_periodic(evt_periodic),
  .evt_alarm   (evt_alarm),
  .evt_update  (evt_update),
  .rd_en       (rd_en),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .irq_n       (irq_n),
  .flags_q     (flags_q)
);

// File: tb/irqf_regfile_test.sv
module irqf_regfile_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_periodic = 0, evt_alarm = 0, evt_update = 0;
  logic       en_periodic = 0, en_alarm = 0, en_update = 0;
  logic       rd_en = 0;
  logic [3:0] rd_addr = 4'd0;
  logic [7:0] rd_data;
  logic       irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference state: bit2 periodic, bit1 alarm, bit0 update
  int m_flags = 0;

  always #10 clk = ~clk;

  irqf_regfile uut (
    .clk(clk), .rst_n(rst_n),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
  );

  function automatic int exp_irq(int en);
    return ((m_flags & en) != 0) ? 1 : 0;
  endfunction

  function automatic int exp_data(int en, int rd, int addr);
    if (!rd) return 0;                       // R9
    if (addr == 12) return (exp_irq(en) << 7) | (m_flags << 4);
    if (addr == 13) return 8'h80;            // R8
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive on falling edge, compare, then advance model at rising edge
  task automatic step(string tag, int ev, int en, int rd, int addr);
    @(negedge clk);
    evt_periodic = ev[2]; evt_alarm = ev[1]; evt_update = ev[0];
    en_periodic = en[2];  en_alarm = en[1];  en_update = en[0];
    rd_en = rd[0]; rd_addr = addr[3:0];
    #2;
    check(tag, int'(rd_data), exp_data(en, rd, addr));
    check("R5", int'(irq_n), 1 - exp_irq(en));
    @(posedge clk);
    if (rd && addr == 12) m_flags = ev & 7;   // R6 clear, R7 keep
    else                  m_flags = (m_flags | ev) & 7;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    step("R1", 0, 0, 1, 12);
    step("R1", 0, 7, 0, 0);
    // R2: events latch with enables off
    step("R2", 1, 0, 0, 0);
    step("R2", 0, 0, 1, 12);          // shows 0x10, clears
    step("R2", 2, 0, 0, 0);
    step("R2", 4, 0, 0, 0);
    // R3: held across idle cycles and status reads
    step("R3", 0, 0, 0, 0);
    step("R3", 0, 0, 0, 0);
    step("R8", 0, 0, 1, 13);          // valid byte, no clear
    step("R9", 0, 0, 1, 5);           // other address, no clear
    // R4: enable change takes effect at once
    step("R4", 0, 2, 1, 13);
    step("R4", 0, 4, 0, 0);
    step("R6", 0, 2, 1, 12);          // shows 0xE0, clears
    step("R6", 0, 7, 1, 12);          // now 0x00
    // R7: event in same cycle as read
    step("R7", 3, 1, 0, 0);
    step("R7", 4, 1, 1, 12);          // shows 0x b0, periodic survives
    step("R7", 0, 4, 1, 12);          // shows 0xC0
    step("R7", 0, 7, 1, 12);
    // R3: mixed pseudo-random run
    for (int i = 0; i < 400; i++) begin
      int ev, en, rd, addr;
      ev   = (($urandom % 4) == 0) ? int'($urandom % 8) : 0;
      en   = int'($urandom % 8);
      rd   = (($urandom % 5) == 0) ? 1 : 0;
      addr = ((($urandom % 3) != 0)) ? 12 : int'($urandom % 16);
      step("R3", ev, en, rd, addr);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule